// File: doc/BRIEF.md
# Byte-Serial 40-bit Accumulator

This block holds a 40-bit running sum next to a multiply/divide unit. Whenever the arithmetic unit signals that a 32-bit result is ready, the result is zero-extended and added into the sum in the same clock edge. No software action is needed, so a chain of multiplies becomes a multiply-accumulate at no extra cost.

Software reaches the sum through a single 8-bit data port. Five byte writes preset it, lowest byte first. The bytes collect in a staging register and the sum is replaced only when the fifth byte arrives. Five byte reads return the sum highest byte first: the byte currently selected is always shown on the read data output, and a read strobe steps to the next byte. Port accesses count only while the arithmetic busy flag is low.

Top module: `byte_acc40`

## Requirements
- R1: After a synchronous reset the sum is zero and both byte counters are zero, so `rdata_o` shows byte 4 (bits 39:32) of a zero sum, which is 0.
- R2: A cycle with `res_valid_i` high (and no completing preset) adds `{8'h00, res_data_i}` to the sum, visible from the next clock edge on.
- R3: Accepted writes fill the sum lowest byte first: the k-th write of a sequence (k = 0..4) supplies bits 8k+7:8k, and the whole 40-bit value takes effect on the edge of the fifth write.
- R4: `rdata_o` shows the byte chosen by the read counter, highest byte first: count 0 shows bits 39:32 and count 4 shows bits 7:0. Each accepted read strobe advances the count, wrapping from 4 back to 0.
- R5: The add is taken modulo 2^40; a carry out of bit 39 is lost.
- R6: While `busy_i` is high, `wr_en_i` and `rd_en_i` are ignored: the sum, the staged bytes and both counters keep their values.
- R7: A result strobe sets both byte counters back to zero.
- R8: Fewer than five writes leave the sum unchanged, so reads never return a partly written value.
- R9: If a result strobe arrives in the same cycle as the fifth preset write, the preset value is loaded and the result is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Arithmetic unit busy; blocks port access |
| res_valid_i | input | 1 | Result-ready strobe |
| res_data_i | input | 32 | Result to add |
| wr_en_i | input | 1 | Byte write strobe |
| wdata_i | input | 8 | Byte write data |
| rd_en_i | input | 1 | Byte read strobe, steps to the next byte |
| rdata_o | output | 8 | Currently selected byte of the sum |

## Verification
Every sum update (an add, or a preset commit on the fifth write) lands on the clock edge where its strobe is sampled. The read counter also moves on the edge of its strobe, and `rdata_o` follows from it with no further register. The bench therefore drives each strobe for exactly one cycle starting at a falling edge and reads `rdata_o` at the next falling edge, one half cycle after the update. Gating and collision cases are checked by reading the full 40-bit value back through the port right after the stimulus.

// File: rtl/acc40_pkg.sv
package acc40_pkg;
    parameter int ACC_W  = 40;
    parameter int RES_W  = 32;
    parameter int BYTE_W = 8;
    localparam int NBYTES = ACC_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES);

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [RES_W-1:0]  res_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic commit;
        acc_t value;
    } preset_t;

    localparam cnt_t LAST_IDX = cnt_t'(NBYTES - 1);

    function automatic acc_t zext(input res_t r);
        return acc_t'(r);
    endfunction

    function automatic cnt_t next_idx(input cnt_t c);
        return (c == LAST_IDX) ? '0 : c + cnt_t'(1);
    endfunction

    // read index 0 selects the highest byte
    function automatic byte_t pick_byte(input acc_t a, input cnt_t idx);
        return a[(NBYTES - 1 - int'(idx)) * BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/acc_port_seq.sv
module acc_port_seq
    import acc40_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic res_valid_i,
    input  logic wr_en_i,
    input  logic rd_en_i,
    output cnt_t wr_cnt_o,
    output cnt_t rd_cnt_o,
    output logic wr_fire_o
);
    logic rd_fire;
    assign wr_fire_o = wr_en_i && !busy_i;
    assign rd_fire   = rd_en_i && !busy_i;

    always_ff @(posedge clk) begin
        if (rst || res_valid_i) begin
            wr_cnt_o <= '0;
            rd_cnt_o <= '0;
        end else begin
            if (wr_fire_o) wr_cnt_o <= next_idx(wr_cnt_o);
            if (rd_fire)   rd_cnt_o <= next_idx(rd_cnt_o);
        end
    end

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !res_valid_i) |=> ($stable(wr_cnt_o) && $stable(rd_cnt_o)));
    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid_i |=> (wr_cnt_o == '0 && rd_cnt_o == '0));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_cnt_o <= LAST_IDX && wr_cnt_o <= LAST_IDX));
endmodule

// File: rtl/acc_stage.sv
module acc_stage
    import acc40_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_fire_i,
    input  cnt_t    wr_cnt_i,
    input  byte_t   wdata_i,
    output preset_t preset_o
);
    byte_t [NBYTES-2:0] stage;

    for (genvar i = 0; i < NBYTES - 1; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                stage[i] <= '0;
            else if (wr_fire_i && wr_cnt_i == cnt_t'(i))
                stage[i] <= wdata_i;
        end
    end

    assign preset_o.commit = wr_fire_i && (wr_cnt_i == LAST_IDX);
    assign preset_o.value  = {wdata_i, stage};
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc40_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    res_valid_i,
    input  res_t    res_data_i,
    input  preset_t preset_i,
    input  cnt_t    rd_cnt_i,
    output byte_t   rdata_o
);
    acc_t sum;

    always_ff @(posedge clk) begin
        if (rst)
            sum <= '0;
        else if (preset_i.commit)
            sum <= preset_i.value;
        else if (res_valid_i)
            sum <= sum + zext(res_data_i);
    end

    assign rdata_o = pick_byte(sum, rd_cnt_i);

    // R2
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid_i && !preset_i.commit) |=> (sum == $past(sum) + zext($past(res_data_i))));
    // R9
    preset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        preset_i.commit |=> (sum == $past(preset_i.value)));
    // R8
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!preset_i.commit && !res_valid_i) |=> $stable(sum));
endmodule

// File: rtl/byte_acc40.sv
module byte_acc40
    import acc40_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        busy_i,
    input  logic        res_valid_i,
    input  logic [31:0] res_data_i,
    input  logic        wr_en_i,
    input  logic [7:0]  wdata_i,
    input  logic        rd_en_i,
    output logic [7:0]  rdata_o
);
    cnt_t    wr_cnt, rd_cnt;
    logic    wr_fire;
    preset_t preset;

    acc_port_seq u_seq (
        .clk(clk), .rst(rst), .busy_i(busy_i), .res_valid_i(res_valid_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .wr_cnt_o(wr_cnt), .rd_cnt_o(rd_cnt), .wr_fire_o(wr_fire)
    );

    acc_stage u_stage (
        .clk(clk), .rst(rst), .wr_fire_i(wr_fire), .wr_cnt_i(wr_cnt),
        .wdata_i(wdata_i), .preset_o(preset)
    );

    acc_core u_core (
        .clk(clk), .rst(rst), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
        .preset_i(preset), .rd_cnt_i(rd_cnt), .rdata_o(rdata_o)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (rdata_o == 8'h00));
endmodule

// File: tb/sim_byte_acc40.sv
module sim_byte_acc40;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy_i = 1'b0;
    logic        res_valid_i = 1'b0;
    logic [31:0] res_data_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rdata_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    byte_acc40 u0 (.*);

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk); wr_en_i = 1'b1; wdata_i = b;
        @(negedge clk); wr_en_i = 1'b0;
    endtask

    task automatic preset(input logic [39:0] v);
        for (int k = 0; k < 5; k++) wr_byte(v[8*k +: 8]);
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); b = rdata_o; rd_en_i = 1'b1;
        @(negedge clk); rd_en_i = 1'b0;
    endtask

    task automatic readback(output logic [39:0] v);
        logic [7:0] b;
        for (int k = 4; k >= 0; k--) begin rd_byte(b); v[8*k +: 8] = b; end
    endtask

    task automatic result(input logic [31:0] r);
        @(negedge clk); res_valid_i = 1'b1; res_data_i = r;
        @(negedge clk); res_valid_i = 1'b0;
    endtask

    task automatic t_reset;
        logic [39:0] v;
        @(negedge clk);
        check("R1 rdata after reset", {32'h0, rdata_o}, 40'h0);
        readback(v);
        check("R1 sum after reset", v, 40'h0);
    endtask

    task automatic t_preset_read;
        logic [39:0] v;
        logic [7:0] b;
        preset(40'h12_3456_789A);
        readback(v);
        check("R3 preset then readback", v, 40'h12_3456_789A);
        rd_byte(b);
        check("R4 read wraps to top byte", {32'h0, b}, 40'h12);
        for (int k = 0; k < 4; k++) rd_byte(b);
        check("R4 fifth byte after wrap", {32'h0, b}, 40'h9A);
    endtask

    task automatic t_accumulate;
        logic [39:0] v;
        preset(40'h00_0000_0005);
        result(32'h0000_0010);
        result(32'hFFFF_FFFF);
        readback(v);
        check("R2 two results added", v, 40'h01_0000_0014);
        preset(40'hFF_FFFF_FFF0);
        result(32'h0000_0020);
        readback(v);
        check("R5 carry out dropped", v, 40'h00_0000_0010);
    endtask

    task automatic t_busy;
        logic [39:0] v;
        logic [7:0] b;
        preset(40'hA1_B2C3_D4E5);
        @(negedge clk); busy_i = 1'b1;
        for (int k = 0; k < 5; k++) wr_byte(8'h77);
        rd_byte(b); rd_byte(b);
        @(negedge clk); busy_i = 1'b0;
        check("R6 busy read kept top byte", {32'h0, rdata_o}, 40'hA1);
        readback(v);
        check("R6 busy writes ignored", v, 40'hA1_B2C3_D4E5);
        preset(40'h01_0203_0405);
        readback(v);
        check("R6 write counter kept at zero", v, 40'h01_0203_0405);
    endtask

    task automatic t_partial;
        logic [39:0] v;
        preset(40'h11_1111_1111);
        wr_byte(8'hE1); wr_byte(8'hE2); wr_byte(8'hE3);
        readback(v);
        check("R8 partial preset invisible", v, 40'h11_1111_1111);
        wr_byte(8'hE4); wr_byte(8'hE5);
        readback(v);
        check("R8 preset completes", v, 40'hE5_E4E3_E2E1);
    endtask

    task automatic t_counter_reset;
        logic [39:0] v;
        logic [7:0] b;
        preset(40'h50_0000_0000);
        wr_byte(8'h99); wr_byte(8'h98);
        rd_byte(b); rd_byte(b);
        result(32'h0000_0001);
        check("R7 read counter back to top", {32'h0, rdata_o}, 40'h50);
        preset(40'h0A_0B0C_0D0E);
        readback(v);
        check("R7 write counter restarted", v, 40'h0A_0B0C_0D0E);
    endtask

    task automatic t_collision;
        logic [39:0] v;
        preset(40'h20_0000_0000);
        wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03); wr_byte(8'h04);
        @(negedge clk);
        wr_en_i = 1'b1; wdata_i = 8'h05; res_valid_i = 1'b1; res_data_i = 32'h1000_0000;
        @(negedge clk);
        wr_en_i = 1'b0; res_valid_i = 1'b0;
        readback(v);
        check("R9 preset beats result", v, 40'h05_0403_0201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_preset_read();
        t_accumulate();
        t_busy();
        t_partial();
        t_counter_reset();
        t_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule